// File: doc/BRIEF.md
# Reconfigurable-Width Static Memory

This block is a static memory of 8192 bits that can be presented to a host as 8192 words of 1 bit, 4096 of 2 bits, 2048 of 4 bits or 1024 of 8 bits. A static configuration input picks the organization. Physically, storage is always 1024 words of 8 bits. The low ten address bits pick a physical word. In narrow organizations, the next address bits pick a lane group within that word. Each lane's enable is derived from those spare bits.

Reads are combinational. The output follows the address (and the lane enables derived from it) with no clock, and holds as long as the address is held. Disabled lanes contribute logic 0, and the selected lanes are OR-merged onto the output channels. Because of this, several modules can share an output bus through an external OR.

Writes are triggered by an active-low write strobe. A small controller with two states turns each strobe pulse into exactly one store:
- ST_IDLE: armed. A strobe sampled low here commits the write and moves to ST_HOLD.
- ST_HOLD: waits for the strobe to be seen high, then returns to ST_IDLE.
- Reset enters ST_HOLD, so a strobe that is low across reset release stores nothing.

Top module: `flexwidth_sram`

## Requirements
- R1: `mode` sets the organization: 0 gives 1 bit per word, 1 gives 2, 2 gives 4 and 3 gives 8. `addr[9:0]` selects the physical word. The lane group g is taken from `addr[10]` upward, using 3, 2, 1 or 0 bits for widths 1, 2, 4 and 8. For width w, group g covers physical bits g*w to g*w+w-1.
- R2: `dout` follows `addr` combinationally, with no clock edge between the address change and valid data.
- R3: With `mode`=3, a write stores `din[7:0]` into the selected word, and a read returns that word on `dout[7:0]`.
- R4: In narrow modes, a write stores `din[j]` into physical bit g*w+j for each j<w. All other bits of the word keep their value.
- R5: In narrow modes, `dout[j]` equals physical bit g*w+j for j<w, and `dout` bits at w and above are 0.
- R6: Address bits above those used by the current mode (above bit 12-mode... i.e. group bits beyond the mode's count) have no effect on reads or writes.
- R7: While `sel_n` is 1, `dout` is all zero and a write strobe stores nothing.
- R8: A write commits at the first clock edge in ST_IDLE where `wr_n` is sampled 0. Holding `wr_n` low for further edges stores nothing more, even if `addr` or `din` change. Another write requires `wr_n` to be sampled 1 first.
- R9: A read of the word being written shows the new value directly after the commit edge.
- R10: After reset the controller is in ST_HOLD. A `wr_n` held low through reset release stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock sampling the write strobe |
| rst_n | input | 1 | Active-low reset of the write controller |
| mode | input | 2 | Static organization select (log2 of word width) |
| addr | input | 13 | Word index in bits 9:0, lane group above |
| sel_n | input | 1 | Active-low module select, gates all lanes |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data; only the low w bits are used in narrow modes |
| dout | output | 8 | Read data, zero on unselected lanes and channels |

## Verification
Two functions can land in the same cycle: the store performed by a strobe and the combinational read of the same word. The bench provokes this by holding an address while a strobe is sampled low. It checks that `dout` still shows the old contents just before the commit edge and the new contents just after it. A second overlap is a strobe held low while the address and data move. The bench judges it by reading back both the first word (which must hold the first data) and the words later addressed under the same pulse (which must be unchanged).

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic [1:0] {
        MODE_X1 = 2'd0,
        MODE_X2 = 2'd1,
        MODE_X4 = 2'd2,
        MODE_X8 = 2'd3
    } width_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } wr_state_e;
endpackage

// File: rtl/fws_wr_fsm.sv
module fws_wr_fsm
    import fws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic commit
);
    wr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!wr_n) state_d = ST_HOLD;
            ST_HOLD: if (wr_n)  state_d = ST_IDLE;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        commit = (state_q == ST_IDLE) && !wr_n;
    end

    // R8
    one_store_per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R8
    rearm_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && wr_n) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/fws_lane_decode.sv
module fws_lane_decode #(
    parameter int LANES = 8,
    parameter int SW    = $clog2(LANES),
    parameter int MW    = $clog2(SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mode,
    input  logic [SW-1:0]    grp_addr,
    input  logic             sel_n,
    output logic [LANES-1:0] lane_en
);
    int grp;
    int shift;

    always_comb begin
        shift = int'(mode);
        grp   = int'(grp_addr) & ((LANES >> shift) - 1);
        for (int i = 0; i < LANES; i++) begin
            lane_en[i] = !sel_n && ((i >> shift) == grp);
        end
    end

    // R1
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> ($countones(lane_en) == (1 << int'(mode))));

    // R7
    lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (lane_en == '0));
endmodule

// File: rtl/fws_store.sv
module fws_store #(
    parameter int WORDS = 1024,
    parameter int LANES = 8,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    widx,
    input  logic [LANES-1:0] wmask,
    input  logic [LANES-1:0] wdata,
    input  logic [AW-1:0]    ridx,
    output logic [LANES-1:0] rword
);
    logic [LANES-1:0] mem [WORDS];
    logic [LANES-1:0] old_word;

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= (mem[widx] & ~wmask) | (wdata & wmask);
    end

    assign rword    = mem[ridx];
    assign old_word = mem[widx];

    // R4
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((mem[$past(widx)] ^ $past(old_word)) & ~$past(wmask)) == '0));

    // R3
    store_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((mem[$past(widx)] ^ $past(wdata)) & $past(wmask)) == '0));
endmodule

// File: rtl/fws_lane_io.sv
module fws_lane_io #(
    parameter int LANES = 8,
    parameter int SW    = $clog2(LANES),
    parameter int MW    = $clog2(SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mode,
    input  logic [LANES-1:0] din,
    input  logic [LANES-1:0] lane_en,
    input  logic [LANES-1:0] rword,
    output logic [LANES-1:0] lane_din,
    output logic [LANES-1:0] dout
);
    logic [LANES-1:0] chan_mask;

    always_comb begin
        chan_mask = '0;
        for (int j = 0; j < LANES; j++) begin
            chan_mask[j] = (j < (1 << int'(mode)));
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_fanout
        always_comb begin
            lane_din[i] = din[i & ((1 << int'(mode)) - 1)];
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if ((i & ((1 << int'(mode)) - 1)) == j)
                    dout[j] = dout[j] | (lane_en[i] & rword[i]);
            end
        end
    end

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout & ~chan_mask) == '0));
endmodule

// File: rtl/flexwidth_sram.sv
module flexwidth_sram #(
    parameter int WORDS = 1024,
    parameter int LANES = 8,
    parameter int AW    = $clog2(WORDS),
    parameter int SW    = $clog2(LANES),
    parameter int MW    = $clog2(SW + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MW-1:0]       mode,
    input  logic [AW+SW-1:0]    addr,
    input  logic                sel_n,
    input  logic                wr_n,
    input  logic [LANES-1:0]    din,
    output logic [LANES-1:0]    dout
);
    logic             commit;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_din;
    logic [LANES-1:0] rword;

    fws_wr_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .commit (commit)
    );

    fws_lane_decode #(.LANES(LANES), .SW(SW), .MW(MW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .grp_addr (addr[AW +: SW]),
        .sel_n    (sel_n),
        .lane_en  (lane_en)
    );

    fws_store #(.WORDS(WORDS), .LANES(LANES), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .widx  (addr[AW-1:0]),
        .wmask (lane_en),
        .wdata (lane_din),
        .ridx  (addr[AW-1:0]),
        .rword (rword)
    );

    fws_lane_io #(.LANES(LANES), .SW(SW), .MW(MW)) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .din      (din),
        .lane_en  (lane_en),
        .rword    (rword),
        .lane_din (lane_din),
        .dout     (dout)
    );

    // R7
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (dout == '0));
endmodule

// File: tb/test_flexwidth_sram.sv
`timescale 1ns/1ps
module test_flexwidth_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd3;
    logic [12:0] addr = '0;
    logic        sel_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [7:0]  din = '0;
    logic [7:0]  dout;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [7:0] model [1024];

    flexwidth_sram i_flexwidth_sram (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
        .sel_n(sel_n), .wr_n(wr_n), .din(din), .dout(dout)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [7:0] exp_read(logic [12:0] a);
        int w = 1 << int'(mode);
        int g = (int'(a) >> 10) & ((8 / w) - 1);
        logic [7:0] r = '0;
        for (int j = 0; j < w; j++) r[j] = model[a[9:0]][g*w + j];
        return r;
    endfunction

    task automatic model_write(logic [12:0] a, logic [7:0] d);
        int w = 1 << int'(mode);
        int g = (int'(a) >> 10) & ((8 / w) - 1);
        for (int j = 0; j < w; j++) model[a[9:0]][g*w + j] = d[j];
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [12:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        if (!sel_n) model_write(a, d);
        @(negedge clk);
    endtask

    task automatic read_chk(string req, logic [12:0] a);
        @(negedge clk);
        addr = a;
        #1;
        check(req, dout, sel_n ? 8'h00 : exp_read(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state, deselected output is zero
        sel_n = 1'b1; #1;
        check("R7 reset", dout, 8'h00);
        rst_n = 1'b1;
        sel_n = 1'b0;

        // R3 R2: full byte-wide sweep
        mode = 2'd3;
        for (int a = 0; a < 1024; a++) do_write(13'(a), 8'((a * 37 + 5) & 255));
        for (int a = 0; a < 1024; a++) read_chk("R3 R2 x8 sweep", 13'(a));

        // R10: strobe held low across reset release stores nothing
        @(negedge clk);
        addr = 13'd5; din = 8'h5A ^ model[5]; wr_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        read_chk("R10", 13'd5);
        do_write(13'd5, 8'hC3);
        read_chk("R10 rearmed", 13'd5);

        // R7: deselected module ignores writes and drives zero
        sel_n = 1'b1;
        read_chk("R7 out", 13'd7);
        do_write(13'd7, 8'h99);
        sel_n = 1'b0;
        read_chk("R7 no store", 13'd7);

        // R8: held strobe, address and data move under it
        @(negedge clk);
        addr = 13'd100; din = 8'h11; wr_n = 1'b0;
        @(negedge clk);
        addr = 13'd101; din = 8'h22;
        @(negedge clk);
        addr = 13'd100; din = 8'h33;
        @(negedge clk);
        wr_n = 1'b1;
        model[100] = 8'h11;
        read_chk("R8 first", 13'd100);
        read_chk("R8 untouched", 13'd101);

        // R9: write and read of same word in same cycle
        @(negedge clk);
        addr = 13'd200; din = 8'hA5 ^ model[200]; wr_n = 1'b0;
        #1;
        check("R9 before edge", dout, model[200]);
        @(posedge clk);
        #1;
        check("R9 after edge", dout, 8'hA5 ^ model[200]);
        model[200] = din;
        @(negedge clk);
        wr_n = 1'b1;

        // R4 R5 R6 R1: narrow modes, ignored upper bits set to 1
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m);
            for (int wd = 0; wd < 32; wd++) begin
                for (int g = 0; g < (8 >> m); g++) begin
                    logic [12:0] a;
                    a = 13'(wd * 29 + 300) & 13'h3FF;
                    a = a | 13'(g << 10) | 13'(~((8 >> m) - 1) << 10) & 13'h1C00;
                    do_write(a, 8'((wd * 7 + g * 3 + m * 11 + 1) & 255));
                end
            end
            for (int wd = 0; wd < 32; wd++) begin
                for (int hi = 0; hi < 8; hi++) begin
                    read_chk("R4 R5 R6 R1 narrow", 13'((wd * 29 + 300) & 1023) | 13'(hi << 10));
                end
            end
        end

        // R3: width 8 view of words changed through narrow writes
        mode = 2'd3;
        for (int wd = 0; wd < 32; wd++) read_chk("R3 R4 merged", 13'((wd * 29 + 300) & 1023));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule